// File: doc/BRIEF.md
# Flash Access Protection Unit

This unit sits between the table-access path of a processor and its program flash. Every table read or table write carries a target address, the program counter of the instruction that issued it, a direction and a source flag that tells internal code apart from an external programmer. The unit decides, in the same cycle, whether a write may reach the array and whether read data passes through or is replaced by zeros.

Program memory is split into a small boot block at address zero followed by equal-sized user blocks. Each block has three protection bits: a code bit that guards it against the external programmer, a write bit that guards it against internal table writes, and a read bit that limits internal table reads to code running inside the same block. The bits live in six configuration bytes that are readable and writable through the normal table path. A write can only clear bits. Only erase requests from the external programmer can set them back to one.

Top module: `flash_prot_unit`

## Requirements
- R1: After reset every protection bit is 1; configuration bytes at even offsets read 0x03 and at odd offsets read 0x01 with the default two user blocks.
- R2: An internal write to a program block asserts wr_grant only when that block's write bit is 1; the boot block uses its own write bit (high byte bit 0 of offsets 2/3).
- R3: An internal read of a block whose read bit is 0 returns 0x00 unless the program counter lies in the same block, in which case rd_raw passes.
- R4: An internal read of a block whose read bit is 1 returns rd_raw for any program counter.
- R5: Code bits do not affect internal accesses; for an external access (acc_ext=1) the code bit alone decides: 0 gives rd_data 0x00 and wr_grant 0, 1 passes rd_raw and grants writes.
- R6: A valid write to a configuration byte ANDs its data into the stored bits, so a bit never goes from 0 to 1 through a write.
- R7: ext_erase_all with acc_ext=1 sets every protection bit to 1 at the next clock edge; with acc_ext=0 the erase inputs are ignored.
- R8: ext_erase_blk with acc_ext=1 sets the three bits of the block selected by erase_sel (value NBLK selects the boot block) to 1 at the next edge.
- R9: Addresses CFG_BASE to CFG_BASE+5 read the configuration: offsets 0/1 code bits, 2/3 write bits, 4/5 read bits; in the low byte bit i is user block i, in the high byte bit 0 is the boot block; other bits read 0. Such accesses never assert wr_grant.
- R10: Addresses outside program memory and configuration space (such as the device-ID area) pass rd_raw on reads and never assert wr_grant.
- R11: wr_grant stays 0 whenever acc_valid is 0 or acc_write is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc | input | ADDR_W | Program counter of the issuing instruction |
| tbl_addr | input | ADDR_W | Target address of the table access |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_ext | input | 1 | 1 when the access comes from the external programmer |
| wr_data | input | 8 | Write data (used for configuration bytes) |
| rd_raw | input | 8 | Data read from the array or ID space |
| ext_erase_all | input | 1 | Full erase request, honoured only with acc_ext |
| ext_erase_blk | input | 1 | Block erase request, honoured only with acc_ext |
| erase_sel | input | ID_W | Block chosen for block erase; NBLK is the boot block |
| rd_data | output | 8 | Read data after protection masking |
| wr_grant | output | 1 | Write may proceed to the array |

## Verification
The assertions take for granted that the access inputs are stable between clock edges and that erase_sel never selects a block index above NBLK when a block erase is honoured. They also assume tbl_addr and pc stay inside the address width. The stimulus draws the target from weighted regions (boot, user, configuration, ID area), holds each input set for a full cycle, keeps configuration writes mostly at 0xFF, and issues periodic external erases so that protected and unprotected states both occur often.

// File: rtl/fap_pkg.sv
`timescale 1ns/1ps
package fap_pkg;
   typedef enum logic [1:0] {
      RG_BOOT  = 2'd0,
      RG_USER  = 2'd1,
      RG_CFG   = 2'd2,
      RG_OTHER = 2'd3
   } region_t;

   localparam int NUM_PAIRS  = 3;   // code, write, read
   localparam int PAIR_CODE  = 0;
   localparam int PAIR_WRITE = 1;
   localparam int PAIR_READ  = 2;
   localparam int CFG_BYTES  = 2 * NUM_PAIRS;
endpackage

// File: rtl/fap_decode.sv
`timescale 1ns/1ps
module fap_decode
   import fap_pkg::*;
#(
   parameter int ADDR_W     = 22,
   parameter int BOOT_BYTES = 2048,
   parameter int BLK_BYTES  = 8192,
   parameter int NBLK       = 2,
   parameter int CFG_BASE   = 32'h300008,
   parameter int ID_W       = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output region_t           region,
   output logic [ID_W-1:0]   blk_id
);
   localparam int BLK_LG = $clog2(BLK_BYTES);
   localparam logic [ADDR_W:0] BOOT_END = (ADDR_W+1)'(BOOT_BYTES);
   localparam logic [ADDR_W:0] PM_END   = (ADDR_W+1)'(NBLK * BLK_BYTES);
   localparam logic [ADDR_W:0] CFG_LO   = (ADDR_W+1)'(CFG_BASE);
   localparam logic [ADDR_W:0] CFG_HI   = (ADDR_W+1)'(CFG_BASE + CFG_BYTES);

   logic [ADDR_W:0] a_x;
   assign a_x = {1'b0, addr};

   always_comb begin
      region = RG_OTHER;
      blk_id = '0;
      if (a_x < BOOT_END) begin
         region = RG_BOOT;
         blk_id = ID_W'(NBLK);
      end else if (a_x < PM_END) begin
         region = RG_USER;
         blk_id = ID_W'(addr >> BLK_LG);
      end else if (a_x >= CFG_LO && a_x < CFG_HI) begin
         region = RG_CFG;
      end
   end
endmodule

// File: rtl/fap_cfg.sv
`timescale 1ns/1ps
module fap_cfg
   import fap_pkg::*;
#(
   parameter int NBLK = 2,
   parameter int ID_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [2:0]      wr_off,
   input  logic [7:0]      wr_data,
   input  logic [2:0]      rd_off,
   input  logic            erase_all,
   input  logic            erase_blk,
   input  logic [ID_W-1:0] erase_sel,
   output logic [NBLK:0]   code_q,
   output logic [NBLK:0]   write_q,
   output logic [NBLK:0]   read_q,
   output logic [7:0]      rd_byte
);
   logic bits_q [NUM_PAIRS][NBLK+1];

   for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
      for (genvar j = 0; j <= NBLK; j++) begin : g_bit
         localparam int         BI  = (j == NBLK) ? 0 : j;
         localparam logic [2:0] OFF = 3'(2 * k + ((j == NBLK) ? 1 : 0));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bits_q[k][j] <= 1'b1;
            else if (erase_all)
               bits_q[k][j] <= 1'b1;
            else if (erase_blk && erase_sel == ID_W'(j))
               bits_q[k][j] <= 1'b1;
            else if (wr_en && wr_off == OFF)
               bits_q[k][j] <= bits_q[k][j] & wr_data[BI];
         end
         if (k == PAIR_CODE) begin : g_c
            assign code_q[j] = bits_q[k][j];
         end else if (k == PAIR_WRITE) begin : g_w
            assign write_q[j] = bits_q[k][j];
         end else begin : g_r
            assign read_q[j] = bits_q[k][j];
         end
      end
   end

   always_comb begin
      rd_byte = '0;
      for (int p = 0; p < NUM_PAIRS; p++) begin
         if (int'(rd_off[2:1]) == p) begin
            if (rd_off[0])
               rd_byte[0] = bits_q[p][NBLK];
            else
               for (int j = 0; j < NBLK; j++) rd_byte[j] = bits_q[p][j];
         end
      end
   end
endmodule

// File: rtl/fap_policy.sv
`timescale 1ns/1ps
module fap_policy
   import fap_pkg::*;
#(
   parameter int NBLK = 2,
   parameter int ID_W = 2
) (
   input  region_t         tgt_region,
   input  logic [ID_W-1:0] tgt_id,
   input  region_t         pc_region,
   input  logic [ID_W-1:0] pc_id,
   input  logic            acc_valid,
   input  logic            acc_write,
   input  logic            acc_ext,
   input  logic [7:0]      rd_raw,
   input  logic [7:0]      cfg_byte,
   input  logic [NBLK:0]   code_q,
   input  logic [NBLK:0]   write_q,
   input  logic [NBLK:0]   read_q,
   output logic [7:0]      rd_data,
   output logic            wr_grant
);
   logic in_prog;
   logic same_blk;
   logic rd_ok;
   logic wr_ok;

   assign in_prog  = (tgt_region == RG_BOOT) || (tgt_region == RG_USER);
   assign same_blk = in_prog && (pc_region == tgt_region) && (pc_id == tgt_id);

   always_comb begin
      if (acc_ext) begin
         rd_ok = code_q[tgt_id];
         wr_ok = code_q[tgt_id];
      end else begin
         rd_ok = read_q[tgt_id] | same_blk;
         wr_ok = write_q[tgt_id];
      end
   end

   always_comb begin
      rd_data  = rd_raw;
      wr_grant = 1'b0;
      case (tgt_region)
         RG_CFG:   rd_data = cfg_byte;
         RG_OTHER: rd_data = rd_raw;
         default: begin
            rd_data  = rd_ok ? rd_raw : 8'h00;
            wr_grant = acc_valid & acc_write & wr_ok;
         end
      endcase
   end
endmodule

// File: rtl/flash_prot_unit.sv
`timescale 1ns/1ps
module flash_prot_unit
   import fap_pkg::*;
#(
   parameter int ADDR_W     = 22,
   parameter int BOOT_BYTES = 2048,
   parameter int BLK_BYTES  = 8192,
   parameter int NBLK       = 2,
   parameter int CFG_BASE   = 32'h300008,
   localparam int ID_W      = $clog2(NBLK + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] tbl_addr,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_ext,
   input  logic [7:0]        wr_data,
   input  logic [7:0]        rd_raw,
   input  logic              ext_erase_all,
   input  logic              ext_erase_blk,
   input  logic [ID_W-1:0]   erase_sel,
   output logic [7:0]        rd_data,
   output logic              wr_grant
);
   if (ADDR_W > 30) begin : g_bad_aw
      $error("ADDR_W must not exceed 30");
   end
   if (BLK_BYTES != (1 << $clog2(BLK_BYTES))) begin : g_bad_blk
      $error("BLK_BYTES must be a power of two");
   end
   if (BOOT_BYTES <= 0 || BOOT_BYTES >= BLK_BYTES) begin : g_bad_boot
      $error("BOOT_BYTES must lie inside the first user block");
   end
   if (NBLK < 1 || NBLK > 8) begin : g_bad_n
      $error("NBLK must be between 1 and 8");
   end
   if (CFG_BASE < NBLK * BLK_BYTES || CFG_BASE + CFG_BYTES > (1 << ADDR_W)) begin : g_bad_cfg
      $error("configuration window must sit above program memory");
   end

   region_t         tgt_region;
   region_t         pc_region;
   logic [ID_W-1:0] tgt_id;
   logic [ID_W-1:0] pc_id;
   logic [2:0]      cfg_off;
   logic [7:0]      cfg_byte;
   logic            cfg_wr;
   logic            erase_all_ok;
   logic            erase_blk_ok;
   logic [NBLK:0]   code_q;
   logic [NBLK:0]   write_q;
   logic [NBLK:0]   read_q;

   assign cfg_off      = 3'(tbl_addr - ADDR_W'(CFG_BASE));
   assign cfg_wr       = acc_valid & acc_write & (tgt_region == RG_CFG);
   assign erase_all_ok = ext_erase_all & acc_ext;
   assign erase_blk_ok = ext_erase_blk & acc_ext;

   fap_decode #(
      .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .BLK_BYTES(BLK_BYTES),
      .NBLK(NBLK), .CFG_BASE(CFG_BASE), .ID_W(ID_W)
   ) u_dec_tgt (
      .addr(tbl_addr), .region(tgt_region), .blk_id(tgt_id)
   );

   fap_decode #(
      .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .BLK_BYTES(BLK_BYTES),
      .NBLK(NBLK), .CFG_BASE(CFG_BASE), .ID_W(ID_W)
   ) u_dec_pc (
      .addr(pc), .region(pc_region), .blk_id(pc_id)
   );

   fap_cfg #(.NBLK(NBLK), .ID_W(ID_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr), .wr_off(cfg_off), .wr_data(wr_data),
      .rd_off(cfg_off),
      .erase_all(erase_all_ok), .erase_blk(erase_blk_ok), .erase_sel(erase_sel),
      .code_q(code_q), .write_q(write_q), .read_q(read_q),
      .rd_byte(cfg_byte)
   );

   fap_policy #(.NBLK(NBLK), .ID_W(ID_W)) u_pol (
      .tgt_region(tgt_region), .tgt_id(tgt_id),
      .pc_region(pc_region), .pc_id(pc_id),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_ext(acc_ext),
      .rd_raw(rd_raw), .cfg_byte(cfg_byte),
      .code_q(code_q), .write_q(write_q), .read_q(read_q),
      .rd_data(rd_data), .wr_grant(wr_grant)
   );
endmodule

// File: rtl/fap_chk.sv
`timescale 1ns/1ps
module fap_chk
   import fap_pkg::*;
#(
   parameter int NBLK = 2,
   parameter int ID_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            acc_valid,
   input logic            acc_write,
   input logic            acc_ext,
   input logic            ext_erase_all,
   input logic            ext_erase_blk,
   input logic [ID_W-1:0] erase_sel,
   input region_t         tgt_region,
   input logic [ID_W-1:0] tgt_id,
   input region_t         pc_region,
   input logic [NBLK:0]   code_q,
   input logic [NBLK:0]   write_q,
   input logic [NBLK:0]   read_q,
   input logic [7:0]      rd_data,
   input logic            wr_grant
);
   logic era_any;
   logic in_prog;
   assign era_any = acc_ext & (ext_erase_all | ext_erase_blk);
   assign in_prog = (tgt_region == RG_BOOT) || (tgt_region == RG_USER);

   AST_BITS_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(era_any) |-> (((code_q & ~$past(code_q)) == '0) &&
                           ((write_q & ~$past(write_q)) == '0) &&
                           ((read_q & ~$past(read_q)) == '0))); // R6

   AST_ERASE_ALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_erase_all && acc_ext) |=> (&code_q && &write_q && &read_q)); // R7

   AST_INT_ERASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      ((ext_erase_all || ext_erase_blk) && !acc_ext && !(acc_valid && acc_write))
      |=> ($stable(code_q) && $stable(write_q) && $stable(read_q))); // R7

   AST_BLK_ERASE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_erase_blk && acc_ext && int'(erase_sel) <= NBLK)
      |=> (code_q[$past(erase_sel)] && write_q[$past(erase_sel)] &&
           read_q[$past(erase_sel)])); // R8

   AST_BOOT_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_ext && tgt_region == RG_BOOT && !write_q[NBLK]) |-> !wr_grant); // R2

   AST_DENIED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_ext && in_prog && !read_q[tgt_id] && pc_region != tgt_region)
      |-> (rd_data == 8'h00)); // R3

   AST_EXT_CODE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_ext && in_prog && !code_q[tgt_id]) |-> (rd_data == 8'h00 && !wr_grant)); // R5

   AST_CFG_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_region == RG_CFG || tgt_region == RG_OTHER) |-> !wr_grant); // R9

   AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_write) |-> !wr_grant); // R11
endmodule

bind flash_prot_unit fap_chk #(.NBLK(NBLK), .ID_W(ID_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .acc_valid(acc_valid), .acc_write(acc_write), .acc_ext(acc_ext),
   .ext_erase_all(ext_erase_all), .ext_erase_blk(ext_erase_blk),
   .erase_sel(erase_sel),
   .tgt_region(tgt_region), .tgt_id(tgt_id), .pc_region(pc_region),
   .code_q(code_q), .write_q(write_q), .read_q(read_q),
   .rd_data(rd_data), .wr_grant(wr_grant)
);

// File: tb/sim_flash_prot_unit.sv
`timescale 1ns/1ps
module sim_flash_prot_unit;
   localparam int AW   = 22;
   localparam int NBLK = 2;
   localparam int IDW  = 2;
   localparam int CFGB = 32'h300008;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  pc = '0, tbl_addr = '0;
   logic           acc_valid = 1'b0, acc_write = 1'b0, acc_ext = 1'b0;
   logic [7:0]     wr_data = '0, rd_raw = '0;
   logic           ext_erase_all = 1'b0, ext_erase_blk = 1'b0;
   logic [IDW-1:0] erase_sel = '0;
   logic [7:0]     rd_data;
   logic           wr_grant;

   int checks = 0;
   int errors = 0;
   bit mq [3][NBLK+1];   // [pair][bit], bit NBLK = boot

   always #4 clk = ~clk;

   flash_prot_unit u0 (
      .clk(clk), .rst_n(rst_n), .pc(pc), .tbl_addr(tbl_addr),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_ext(acc_ext),
      .wr_data(wr_data), .rd_raw(rd_raw),
      .ext_erase_all(ext_erase_all), .ext_erase_blk(ext_erase_blk),
      .erase_sel(erase_sel), .rd_data(rd_data), .wr_grant(wr_grant)
   );

   // 0 boot, 1 user, 2 config, 3 other
   function automatic int rgn(logic [AW-1:0] a);
      if (a < 22'h800) return 0;
      if (a < 22'h4000) return 1;
      if (int'(a) >= CFGB && int'(a) < CFGB + 6) return 2;
      return 3;
   endfunction

   function automatic int bid(logic [AW-1:0] a);
      return (a < 22'h800) ? NBLK : int'(a >> 13);
   endfunction

   function automatic logic [7:0] cfg_byte(int off);
      logic [7:0] b = '0;
      if (off[0]) b[0] = mq[off/2][NBLK];
      else for (int j = 0; j < NBLK; j++) b[j] = mq[off/2][j];
      return b;
   endfunction

   function automatic logic [7:0] exp_rd(logic [AW-1:0] a, logic [AW-1:0] p,
                                         logic x, logic [7:0] raw);
      int r = rgn(a);
      int b;
      if (r == 2) return cfg_byte(int'(a) - CFGB);
      if (r == 3) return raw;
      b = bid(a);
      if (x) return mq[0][b] ? raw : 8'h00;
      if (mq[2][b]) return raw;
      if (rgn(p) == r && bid(p) == b) return raw;
      return 8'h00;
   endfunction

   function automatic logic exp_gr(logic [AW-1:0] a, logic v, logic w, logic x);
      int r = rgn(a);
      if (!(v && w) || r >= 2) return 1'b0;
      return x ? mq[0][bid(a)] : mq[1][bid(a)];
   endfunction

   function automatic string rd_tag(logic [AW-1:0] a, logic x);
      int r = rgn(a);
      if (r == 2) return "R9";
      if (r == 3) return "R10";
      if (x) return "R5";
      return mq[2][bid(a)] ? "R4" : "R3";
   endfunction

   function automatic string wr_tag(logic [AW-1:0] a, logic v, logic w, logic x);
      int r = rgn(a);
      if (!(v && w)) return "R11";
      if (r == 2) return "R9";
      if (r == 3) return "R10";
      return x ? "R5" : "R2";
   endfunction

   task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
      end
   endtask

   task automatic step(logic [AW-1:0] a, logic [AW-1:0] p, logic v, logic w,
                       logic x, logic [7:0] d, logic [7:0] raw,
                       logic ea, logic eb, logic [IDW-1:0] es);
      @(negedge clk);
      tbl_addr = a; pc = p; acc_valid = v; acc_write = w; acc_ext = x;
      wr_data = d; rd_raw = raw; ext_erase_all = ea; ext_erase_blk = eb;
      erase_sel = es;
      #1;
      chk(rd_tag(a, x), "rd_data", rd_data, exp_rd(a, p, x, raw));
      chk(wr_tag(a, v, w, x), "wr_grant", {7'b0, wr_grant}, {7'b0, exp_gr(a, v, w, x)});
      @(posedge clk);
      for (int k = 0; k < 3; k++) begin
         for (int j = 0; j <= NBLK; j++) begin
            if (x && ea) mq[k][j] = 1'b1;
            else if (x && eb && int'(es) == j) mq[k][j] = 1'b1;
            else if (v && w && rgn(a) == 2) begin
               int off = int'(a) - CFGB;
               if (off / 2 == k) begin
                  if (off[0] && j == NBLK) mq[k][j] = mq[k][j] & d[0];
                  if (!off[0] && j < NBLK) mq[k][j] = mq[k][j] & d[j];
               end
            end
         end
      end
   endtask

   // read a config byte through the normal path
   task automatic rd_cfg(int off, logic [7:0] exp, string tag);
      @(negedge clk);
      tbl_addr = AW'(CFGB + off); acc_valid = 1'b1; acc_write = 1'b0;
      acc_ext = 1'b0; ext_erase_all = 1'b0; ext_erase_blk = 1'b0;
      #1;
      chk(tag, "cfg byte", rd_data, exp);
   endtask

   function automatic logic [AW-1:0] rnd_addr();
      int s = int'($urandom % 8);
      if (s < 5) return AW'($urandom % 32'h4000);
      if (s < 7) return AW'(CFGB + int'($urandom % 6));
      return ($urandom % 2 == 0) ? AW'(22'h3FFFF0 + ($urandom % 16)) : 22'h200000;
   endfunction

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int k = 0; k < 3; k++)
         for (int j = 0; j <= NBLK; j++) mq[k][j] = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state of all six bytes
      for (int o = 0; o < 6; o++) rd_cfg(o, o[0] ? 8'h01 : 8'h03, "R1");

      // R2: clear write bit of user block 0, then writes
      step(AW'(CFGB + 2), 22'h0, 1, 1, 0, 8'hFE, 8'h00, 0, 0, 0);
      step(22'h1000, 22'h0, 1, 1, 0, 8'h00, 8'h5A, 0, 0, 0);
      step(22'h2100, 22'h0, 1, 1, 0, 8'h00, 8'h5A, 0, 0, 0);
      // R6: attempt to set it back
      step(AW'(CFGB + 2), 22'h0, 1, 1, 0, 8'hFF, 8'h00, 0, 0, 0);
      rd_cfg(2, 8'h02, "R6");
      // R2: boot write bit via high byte
      step(AW'(CFGB + 3), 22'h0, 1, 1, 0, 8'h00, 8'h00, 0, 0, 0);
      step(22'h0010, 22'h0, 1, 1, 0, 8'h00, 8'h11, 0, 0, 0);
      // R3: boot read bit cleared; foreign and local program counter
      step(AW'(CFGB + 5), 22'h0, 1, 1, 0, 8'h00, 8'h00, 0, 0, 0);
      step(22'h0100, 22'h3000, 1, 0, 0, 8'h00, 8'hA5, 0, 0, 0);
      step(22'h0100, 22'h0400, 1, 0, 0, 8'h00, 8'hA5, 0, 0, 0);
      // R4: block 1 unprotected, read from boot code
      step(22'h3000, 22'h0100, 1, 0, 0, 8'h00, 8'h3C, 0, 0, 0);
      // R7: internal erase ignored
      step(22'h3000, 22'h0, 0, 0, 0, 8'h00, 8'h00, 1, 1, 2'd2);
      rd_cfg(5, 8'h00, "R7");
      // R5: clear code bit of block 1
      step(AW'(CFGB + 0), 22'h0, 1, 1, 0, 8'hFD, 8'h00, 0, 0, 0);
      step(22'h3004, 22'h0, 1, 0, 0, 8'h00, 8'h77, 0, 0, 0);
      step(22'h3004, 22'h0, 1, 0, 1, 8'h00, 8'h77, 0, 0, 0);
      step(22'h3004, 22'h0, 1, 1, 1, 8'h00, 8'h77, 0, 0, 0);
      // R8: external block erase of block 1
      step(22'h3FFFFE, 22'h0, 0, 0, 1, 8'h00, 8'h00, 0, 1, 2'd1);
      rd_cfg(0, 8'h03, "R8");
      // R10: device-ID area
      step(22'h3FFFFE, 22'h0, 1, 0, 0, 8'h00, 8'h4C, 0, 0, 0);
      step(22'h3FFFFE, 22'h0, 1, 1, 0, 8'h00, 8'h4C, 0, 0, 0);
      // R7: external full erase
      step(22'h0, 22'h0, 0, 0, 1, 8'h00, 8'h00, 1, 0, 0);
      for (int o = 0; o < 6; o++) rd_cfg(o, o[0] ? 8'h01 : 8'h03, "R7");

      // constrained random mix
      for (int i = 0; i < 1500; i++) begin
         logic [AW-1:0] a = rnd_addr();
         logic [AW-1:0] p = ($urandom % 2 == 0) ? (a ^ AW'($urandom % 64))
                                                : AW'($urandom % 32'h4000);
         logic v  = ($urandom % 8) != 0;
         logic w  = ($urandom % 2) == 0;
         logic x  = ($urandom % 4) == 0;
         logic [7:0] d = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
         logic ea = ($urandom % 24) == 0;
         logic eb = ($urandom % 12) == 0;
         logic [IDW-1:0] es = IDW'($urandom % (NBLK + 1));
         step(a, p, v, w, x, d, 8'($urandom), ea, eb, es);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule